// File: doc/BRIEF.md
# Two-Mode Pulse Accumulator

This block is an 8-bit accumulator fed by one external pin. It can run as an event counter, where each pin transition of the chosen polarity adds one to the count. It can also run as a gated timer, where the count advances once every 64 bus-clock cycles for as long as the pin is held at its active level. A single polarity bit serves both modes. In event mode it picks the counted edge. In gated mode it picks the active level of the gate.

The pin passes through a two-flop synchroniser before any logic sees it. The count sets an overflow flag when it wraps from its all-ones value to zero. An edge flag sets on the selected edge in event mode, and on the edge that ends the gate in gated mode. Each flag is cleared by writing a one to it and has its own interrupt enable. A small register bus gives access to the control bits, the count (readable and writable) and the flags. The read data is combinational from the address.

Register map (bus_addr): 0 = control, 1 = count, 2 = flags, 3 = reads zero. Control bits: bit 0 enable, bit 1 gated mode (0 = event counting), bit 2 polarity, bit 4 overflow interrupt enable, bit 5 edge interrupt enable. Flags bits: bit 0 overflow, bit 1 edge.

Top module: `pulse_acc`

## Requirements
- R1: After reset, the control, count and flags registers read 0, and both interrupt outputs are low.
- R2: While control bit 0 (enable) is 0, pin activity changes neither the count nor either flag.
- R3: In event mode (control bit 1 = 0), the count increments once per rising pin edge when control bit 2 = 1, and once per falling edge when bit 2 = 0. Edges of the other polarity are ignored.
- R4: In gated mode (control bit 1 = 1), the count increments exactly once per 64 clock cycles that the synchronised pin spends at its active level. The active level is high when control bit 2 = 0 and low when bit 2 = 1. The count holds while the pin is inactive. The divide-by-64 time base runs freely from reset.
- R5: An increment from 0xFF gives 0x00 and sets flags bit 0 (overflow). An increment to any other value leaves that flag unchanged.
- R6: Flags bit 1 (edge) sets on the counted edge in event mode. In gated mode it sets only on the edge that ends the active level: falling when bit 2 = 0, rising when bit 2 = 1.
- R7: Writing the flags register clears each flag whose data bit is 1 and leaves the others. A flag that sets in the same cycle as its clear stays set.
- R8: irq_ovf equals flags bit 0 AND control bit 4, and irq_edge equals flags bit 1 AND control bit 5.
- R9: A write to the count register is read back unchanged. It overrides an increment in the same cycle, and no overflow flag results from that cycle.
- R10: A pin change is counted on the third rising clock edge after it is applied. The count is still unchanged after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | External accumulator pin, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_edge | output | 1 | Edge interrupt request |

## Verification
Several internal faults show up at the ports within a few cycles. A wrong synchroniser depth moves the count update away from the third clock edge after a pin change. A mixed-up polarity decode counts the wrong edge, so the count is off by one after a single pulse. A prescaler fault, or a gate decode that counts while inactive, shows as a gated total other than four after exactly 256 active cycles, or as any growth during an inactive window. Flag and priority faults are read back through the flags and count registers. This covers a missed wrap at 0xFF, a leading-edge flag in gated mode, a lost write against a simultaneous increment, and a clear that beats a set, each visible on the cycle after the event.

// File: rtl/pacc_pkg.sv
`timescale 1ns/1ps
package pacc_pkg;
   typedef enum logic [1:0] {
      REG_CTRL  = 2'd0,
      REG_COUNT = 2'd1,
      REG_FLAGS = 2'd2,
      REG_NONE  = 2'd3
   } reg_addr_e;

   localparam int CTRL_EN      = 0;
   localparam int CTRL_GATED   = 1;
   localparam int CTRL_POL     = 2;
   localparam int CTRL_OVF_IE  = 4;
   localparam int CTRL_EDGE_IE = 5;

   localparam int FLAG_OVF  = 0;
   localparam int FLAG_EDGE = 1;
endpackage

// File: rtl/pacc_sync.sv
`timescale 1ns/1ps
module pacc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES >= 2) begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end else begin : g_bad_stages
         $error("pacc_sync: STAGES must be 0 or at least 2");
      end
   endgenerate
endmodule

// File: rtl/pacc_prescale.sv
`timescale 1ns/1ps
module pacc_prescale #(
   parameter int DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 2 || (DIV & (DIV - 1)) != 0) begin : g_bad_div
         $error("pacc_prescale: DIV must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0] phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= '0;
      else        phase <= phase + W'(1);
   end

   assign tick = (phase == W'(DIV - 1));

   // R4
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/pacc_core.sv
`timescale 1ns/1ps
module pacc_core #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_s,
   input  logic             tick,
   input  logic             en,
   input  logic             gated,
   input  logic             pol,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             clr_ovf,
   input  logic             clr_edge,
   output logic [CNT_W-1:0] count,
   output logic             ovf_flag,
   output logic             edge_flag
);
   logic pin_q;
   logic rise, fall, sel_edge, edge_hit, active, inc, at_max, ovf_set;

   always_comb begin
      rise     = pin_s & ~pin_q;
      fall     = ~pin_s & pin_q;
      sel_edge = pol ? rise : fall;
      edge_hit = en & sel_edge;
      active   = pin_s ^ pol;
      inc      = en & (gated ? (tick & active) : sel_edge);
      at_max   = (count == {CNT_W{1'b1}});
      ovf_set  = inc & at_max & ~cnt_wr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q     <= 1'b0;
         count     <= '0;
         ovf_flag  <= 1'b0;
         edge_flag <= 1'b0;
      end else begin
         pin_q <= pin_s;
         if (cnt_wr)   count <= cnt_wdata;
         else if (inc) count <= count + CNT_W'(1);
         ovf_flag  <= ovf_set  | (ovf_flag  & ~clr_ovf);
         edge_flag <= edge_hit | (edge_flag & ~clr_edge);
      end
   end

   // R2
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !cnt_wr) |=> $stable(count));
   // R2
   edge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !edge_flag) |=> !edge_flag);
   // R3
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr |=> (count == $past(count) || count == CNT_W'($past(count) + CNT_W'(1))));
   // R5
   wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cnt_wr) && $past(count) == {CNT_W{1'b1}} && count == '0) |-> ovf_flag);
   // R7
   edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_edge && !edge_hit) |=> !edge_flag);
   // R9
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (count == $past(cnt_wdata)));
endmodule

// File: rtl/pulse_acc.sv
`timescale 1ns/1ps
module pulse_acc #(
   parameter int CNT_W       = 8,
   parameter int DIV         = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   output logic             irq_ovf,
   output logic             irq_edge
);
   import pacc_pkg::*;

   localparam int DATA_W = CNT_W;

   generate
      if (CNT_W < 6) begin : g_bad_width
         $error("pulse_acc: CNT_W must be at least 6 to hold the control bits");
      end
   endgenerate

   logic             pin_s, tick;
   logic             en_q, gated_q, pol_q, ovf_ie_q, edge_ie_q;
   logic             wr_ctrl, wr_count, wr_flags;
   logic [CNT_W-1:0] count;
   logic             ovf_flag, edge_flag;

   pacc_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s));

   pacc_prescale #(.DIV(DIV)) pre_i (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   always_comb begin
      wr_ctrl  = bus_wr && (bus_addr == REG_CTRL);
      wr_count = bus_wr && (bus_addr == REG_COUNT);
      wr_flags = bus_wr && (bus_addr == REG_FLAGS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         gated_q   <= 1'b0;
         pol_q     <= 1'b0;
         ovf_ie_q  <= 1'b0;
         edge_ie_q <= 1'b0;
      end else if (wr_ctrl) begin
         en_q      <= bus_wdata[CTRL_EN];
         gated_q   <= bus_wdata[CTRL_GATED];
         pol_q     <= bus_wdata[CTRL_POL];
         ovf_ie_q  <= bus_wdata[CTRL_OVF_IE];
         edge_ie_q <= bus_wdata[CTRL_EDGE_IE];
      end
   end

   pacc_core #(.CNT_W(CNT_W)) core_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_s     (pin_s),
      .tick      (tick),
      .en        (en_q),
      .gated     (gated_q),
      .pol       (pol_q),
      .cnt_wr    (wr_count),
      .cnt_wdata (bus_wdata),
      .clr_ovf   (wr_flags & bus_wdata[FLAG_OVF]),
      .clr_edge  (wr_flags & bus_wdata[FLAG_EDGE]),
      .count     (count),
      .ovf_flag  (ovf_flag),
      .edge_flag (edge_flag)
   );

   always_comb begin
      case (bus_addr)
         REG_CTRL:  bus_rdata = DATA_W'({edge_ie_q, ovf_ie_q, 1'b0, pol_q, gated_q, en_q});
         REG_COUNT: bus_rdata = count;
         REG_FLAGS: bus_rdata = DATA_W'({edge_flag, ovf_flag});
         default:   bus_rdata = '0;
      endcase
   end

   assign irq_ovf  = ovf_flag  & ovf_ie_q;
   assign irq_edge = edge_flag & edge_ie_q;

   // R8
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_ovf) |-> ($rose(ovf_flag) || $rose(ovf_ie_q)));
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!irq_ovf && !irq_edge) || rst_n);
endmodule

// File: tb/pulse_acc_tb_top.sv
`timescale 1ns/1ps
module pulse_acc_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_in = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_ovf, irq_edge;

   int checks = 0;
   int errors = 0;

   localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_FLG = 2'd2;

   always #2.5 clk = ~clk;

   pulse_acc dut_i (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_ovf(irq_ovf), .irq_edge(irq_edge));

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // called at a negedge; consumes one clock
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // called at a negedge; consumes no clock
   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse();
      pin_in = 1'b1; idle(4);
      pin_in = 1'b0; idle(4);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(A_CTRL, d); check("R1 ctrl", d, 8'h00);
      rd(A_CNT, d);  check("R1 count", d, 8'h00);
      rd(A_FLG, d);  check("R1 flags", d, 8'h00);
      check("R1 irqs", {6'd0, irq_edge, irq_ovf}, 8'h00);
   endtask

   task automatic t_disabled();
      logic [7:0] d;
      wr(A_CTRL, 8'h04);
      pulse(); pulse();
      rd(A_CNT, d); check("R2 count held", d, 8'h00);
      rd(A_FLG, d); check("R2 flags untouched", d, 8'h00);
   endtask

   task automatic t_event();
      logic [7:0] d;
      wr(A_CTRL, 8'h05);
      pulse(); pulse(); pulse();
      rd(A_CNT, d); check("R3 rising count", d, 8'h03);
      rd(A_FLG, d); check("R6 event edge flag", d, 8'h02);
      wr(A_CTRL, 8'h01); wr(A_CNT, 8'h00); wr(A_FLG, 8'h03);
      pin_in = 1'b1; idle(4);
      rd(A_CNT, d); check("R3 rising ignored", d, 8'h00);
      rd(A_FLG, d); check("R6 no flag on other edge", d, 8'h00);
      pin_in = 1'b0; idle(4);
      rd(A_CNT, d); check("R3 falling counted", d, 8'h01);
      rd(A_FLG, d); check("R6 falling flag", d, 8'h02);
   endtask

   task automatic t_latency();
      logic [7:0] d;
      wr(A_CTRL, 8'h05); wr(A_CNT, 8'h00); idle(3);
      pin_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rd(A_CNT, d); check("R10 unchanged after two edges", d, 8'h00);
      @(negedge clk);
      rd(A_CNT, d); check("R10 counted on third edge", d, 8'h01);
      pin_in = 1'b0; idle(4);
   endtask

   task automatic t_gated_high();
      logic [7:0] d;
      wr(A_CTRL, 8'h03); wr(A_CNT, 8'h00); wr(A_FLG, 8'h03);
      pin_in = 1'b1; idle(5);
      rd(A_FLG, d); check("R6 no flag on leading edge", d, 8'h00);
      idle(251);
      pin_in = 1'b0; idle(10);
      rd(A_CNT, d); check("R4 active-high 256 cycles", d, 8'h04);
      rd(A_FLG, d); check("R6 trailing edge flag", d, 8'h02);
      idle(256);
      rd(A_CNT, d); check("R4 inactive holds", d, 8'h04);
   endtask

   task automatic t_gated_low();
      logic [7:0] d;
      wr(A_CTRL, 8'h00);
      pin_in = 1'b1; idle(5);
      wr(A_CNT, 8'h00); wr(A_FLG, 8'h03); wr(A_CTRL, 8'h07);
      idle(300);
      rd(A_CNT, d); check("R4 high is inactive", d, 8'h00);
      pin_in = 1'b0; idle(192);
      pin_in = 1'b1; idle(10);
      rd(A_CNT, d); check("R4 active-low 192 cycles", d, 8'h03);
      rd(A_FLG, d); check("R6 rising trailing flag", d, 8'h02);
      wr(A_CTRL, 8'h00);
      pin_in = 1'b0; idle(5);
   endtask

   task automatic t_overflow();
      logic [7:0] d;
      wr(A_CTRL, 8'h05); wr(A_CNT, 8'hFE); wr(A_FLG, 8'h03);
      pulse();
      rd(A_CNT, d); check("R5 reach FF", d, 8'hFF);
      rd(A_FLG, d); check("R5 no overflow yet", d & 8'h01, 8'h00);
      pulse();
      rd(A_CNT, d); check("R5 wrap to 00", d, 8'h00);
      rd(A_FLG, d); check("R5 overflow flag", d, 8'h03);
      check("R8 irq_ovf masked", {7'd0, irq_ovf}, 8'h00);
      wr(A_CTRL, 8'h15);
      check("R8 irq_ovf enabled", {7'd0, irq_ovf}, 8'h01);
      check("R8 irq_edge masked", {7'd0, irq_edge}, 8'h00);
      wr(A_CTRL, 8'h35);
      check("R8 irq_edge enabled", {7'd0, irq_edge}, 8'h01);
      wr(A_FLG, 8'h02);
      rd(A_FLG, d); check("R7 clear edge only", d, 8'h01);
      check("R8 irq_edge drops", {7'd0, irq_edge}, 8'h00);
      wr(A_FLG, 8'h01);
      rd(A_FLG, d); check("R7 clear overflow", d, 8'h00);
      check("R8 irq_ovf drops", {7'd0, irq_ovf}, 8'h00);
   endtask

   task automatic t_priority();
      logic [7:0] d;
      wr(A_CTRL, 8'h05); wr(A_CNT, 8'hFF); wr(A_FLG, 8'h03); idle(3);
      pin_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr(A_CNT, 8'h40);
      rd(A_CNT, d); check("R9 write beats increment", d, 8'h40);
      rd(A_FLG, d); check("R9 no overflow from override", d, 8'h02);
      pin_in = 1'b0; idle(4);
      wr(A_FLG, 8'h03);
      pin_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr(A_FLG, 8'h02);
      rd(A_FLG, d); check("R7 set beats clear", d, 8'h02);
      pin_in = 1'b0; idle(4);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_disabled();
      t_event();
      t_latency();
      t_gated_high();
      t_gated_low();
      t_overflow();
      t_priority();
      finish_run();
   end
endmodule